// File: doc/BRIEF.md
# Masked Vector Execution Unit

This block is the vector half of a vector processor. It holds a bank of equal-length vector registers, a register giving the number of elements currently in use, and a one-bit-per-element mask. One instruction at a time is accepted through a valid/ready handshake. The unit then walks the active elements from index 0 upwards, handling one element per clock cycle, and raises a done pulse once it has finished.

Arithmetic comes in three forms: register with register, scalar with register, and unary. A compare instruction writes the mask and leaves every vector register untouched. Any arithmetic instruction can be issued in masked mode. In that mode an element whose mask bit is clear is skipped, so the destination element keeps the value it already had. Elements at or beyond the active length are never written. A fill port loads single elements while the unit is idle. A combinational read port, together with the length and mask outputs, lets the surrounding datapath observe the unit's state.

Top module: `vmask_exec_unit`

## Requirements
- R1: After synchronous reset, busy and done are 0, in_ready is 1, the active length is VLEN_MAX, every mask bit is 0 and every register element is 0.
- R2: Opcode 8 (set length) sets the active length to the scalar operand read as unsigned, clamped to VLEN_MAX. It never raises busy, and done pulses in the cycle after acceptance.
- R3: Register-register arithmetic with use_scalar=0 writes dst[i] = A op B for every active i, where A=src_a[i] and B=src_b[i], computed in two's complement with wraparound at ELEM_W bits. The opcodes are 0 add, 1 subtract (A-B), 2 bitwise AND and 3 bitwise OR.
- R4: With use_scalar=1, operand A is the scalar operand in place of src_a[i]. Subtract then gives scalar - src_b[i].
- R5: Opcode 4 (negate) writes dst[i] = -src_b[i].
- R6: Opcodes 5 (greater), 6 (equal) and 7 (less) compare A with B as signed values for each active element i and set mask bit i to the result. All mask bits at positions at or above the length are cleared. The mask_en flag has no effect on a compare, and no vector register changes.
- R7: When mask_en=1, an arithmetic instruction writes only those active elements whose mask bit is 1. Every other destination element keeps its old value.
- R8: Destination elements at positions at or above the active length are never modified.
- R9: in_ready equals !busy. For an accepted operation with length l>0, busy is high for exactly l cycles and done pulses for one cycle as busy falls. With l=0, done pulses in the cycle after acceptance and nothing is written.
- R10: The fill port writes one element while the unit is idle. Fill requests and instruction offers made while busy are ignored.
- R11: rd_data shows element rd_idx of register rd_reg combinationally. mask_bits bit i is mask element i, and vlen is the active length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, instruction can be taken |
| in_op | input | 4 | Opcode (0 add, 1 sub, 2 and, 3 or, 4 neg, 5 gt, 6 eq, 7 lt, 8 set length) |
| in_use_scalar | input | 1 | Take operand A from in_scalar |
| in_mask_en | input | 1 | Masked execution |
| in_dst | input | RW | Destination register |
| in_src_a | input | RW | Source register A |
| in_src_b | input | RW | Source register B |
| in_scalar | input | ELEM_W | Scalar operand / new length |
| fill_en | input | 1 | Fill one element (idle only) |
| fill_reg | input | RW | Fill register |
| fill_idx | input | IDXW | Fill element index |
| fill_data | input | ELEM_W | Fill value |
| rd_reg | input | RW | Read register |
| rd_idx | input | IDXW | Read element index |
| rd_data | output | ELEM_W | Read value |
| vlen | output | LW | Active vector length |
| mask_bits | output | VLEN_MAX | Mask register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a masked write whose mask came from a compare run at a shorter length than the write that follows. That requires a compare at a long length, a second compare at a shorter length to clear the tail bits, and then a masked operation at an intermediate length. The stimulus table runs exactly that chain in sequence. The second case is traffic that arrives while an operation is running. A directed test holds a conflicting instruction and a fill request on the inputs during a long operation, then reads the registers they would have hit. Zero-length operations and the clamping of an oversized length are covered by directed steps after the table.

// File: rtl/vexu_pkg.sv
`timescale 1ns/1ps
package vexu_pkg;

    typedef enum logic [3:0] {
        VOP_ADD  = 4'd0,
        VOP_SUB  = 4'd1,
        VOP_AND  = 4'd2,
        VOP_OR   = 4'd3,
        VOP_NEG  = 4'd4,
        VOP_CGT  = 4'd5,
        VOP_CEQ  = 4'd6,
        VOP_CLT  = 4'd7,
        VOP_SETL = 4'd8
    } vop_e;

    typedef struct packed {
        vop_e op;
        logic use_scalar;
        logic mask_en;
    } vctl_t;

    function automatic logic is_cmp(vop_e op);
        return (op == VOP_CGT) || (op == VOP_CEQ) || (op == VOP_CLT);
    endfunction

    function automatic logic is_arith(vop_e op);
        return (op == VOP_ADD) || (op == VOP_SUB) || (op == VOP_AND) ||
               (op == VOP_OR)  || (op == VOP_NEG);
    endfunction

endpackage

// File: rtl/vexu_alu.sv
`timescale 1ns/1ps
module vexu_alu
    import vexu_pkg::*;
#(
    parameter int ELEM_W = 16
) (
    input  vop_e                     op,
    input  logic signed [ELEM_W-1:0] a,
    input  logic signed [ELEM_W-1:0] b,
    output logic        [ELEM_W-1:0] res,
    output logic                     rel
);
    always_comb begin
        res = '0;
        rel = 1'b0;
        case (op)
            VOP_ADD: res = a + b;
            VOP_SUB: res = a - b;
            VOP_AND: res = a & b;
            VOP_OR:  res = a | b;
            VOP_NEG: res = -b;
            VOP_CGT: rel = (a > b);
            VOP_CEQ: rel = (a == b);
            VOP_CLT: rel = (a < b);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/vexu_regfile.sv
`timescale 1ns/1ps
module vexu_regfile #(
    parameter int N_REGS   = 8,
    parameter int VLEN_MAX = 16,
    parameter int ELEM_W   = 16,
    localparam int RW      = $clog2(N_REGS),
    localparam int IDXW    = $clog2(VLEN_MAX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RW-1:0]     wreg,
    input  logic [IDXW-1:0]   widx,
    input  logic [ELEM_W-1:0] wdata,
    input  logic [RW-1:0]     ra_reg,
    input  logic [RW-1:0]     rb_reg,
    input  logic [IDXW-1:0]   rab_idx,
    output logic [ELEM_W-1:0] ra_data,
    output logic [ELEM_W-1:0] rb_data,
    input  logic [RW-1:0]     rc_reg,
    input  logic [IDXW-1:0]   rc_idx,
    output logic [ELEM_W-1:0] rc_data
);
    logic [ELEM_W-1:0] mem [N_REGS][VLEN_MAX];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < N_REGS; r++)
                for (int e = 0; e < VLEN_MAX; e++)
                    mem[r][e] <= '0;
        end else if (we) begin
            mem[wreg][widx] <= wdata;
        end
    end

    assign ra_data = mem[ra_reg][rab_idx];
    assign rb_data = mem[rb_reg][rab_idx];
    assign rc_data = mem[rc_reg][rc_idx];
endmodule

// File: rtl/vexu_seq.sv
`timescale 1ns/1ps
module vexu_seq
    import vexu_pkg::*;
#(
    parameter int N_REGS   = 8,
    parameter int VLEN_MAX = 16,
    parameter int ELEM_W   = 16,
    localparam int RW      = $clog2(N_REGS),
    localparam int IDXW    = $clog2(VLEN_MAX),
    localparam int LW      = $clog2(VLEN_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  vctl_t               in_ctl,
    input  logic [RW-1:0]       in_dst,
    input  logic [RW-1:0]       in_a,
    input  logic [RW-1:0]       in_b,
    input  logic [ELEM_W-1:0]   in_scalar,
    input  logic                rel_bit,
    output logic                busy,
    output logic                done,
    output logic [IDXW-1:0]     idx,
    output logic [LW-1:0]       vl,
    output logic [VLEN_MAX-1:0] mask,
    output vctl_t               cur_ctl,
    output logic [RW-1:0]       cur_dst,
    output logic [RW-1:0]       cur_a,
    output logic [RW-1:0]       cur_b,
    output logic [ELEM_W-1:0]   cur_scalar
);
    logic          last;
    logic [LW-1:0] new_len;

    assign last    = (LW'(idx) == vl - LW'(1));
    assign new_len = (in_scalar > ELEM_W'(VLEN_MAX)) ? LW'(VLEN_MAX) : in_scalar[LW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            idx        <= '0;
            vl         <= LW'(VLEN_MAX);
            mask       <= '0;
            cur_ctl    <= '0;
            cur_dst    <= '0;
            cur_a      <= '0;
            cur_b      <= '0;
            cur_scalar <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (is_cmp(cur_ctl.op))
                    mask[idx] <= rel_bit;
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + IDXW'(1);
                end
            end else if (in_valid) begin
                cur_ctl    <= in_ctl;
                cur_dst    <= in_dst;
                cur_a      <= in_a;
                cur_b      <= in_b;
                cur_scalar <= in_scalar;
                if (in_ctl.op == VOP_SETL) begin
                    vl   <= new_len;
                    done <= 1'b1;
                end else if (vl == '0 || !(is_arith(in_ctl.op) || is_cmp(in_ctl.op))) begin
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    idx  <= '0;
                    if (is_cmp(in_ctl.op))
                        mask <= '0;
                end
            end
        end
    end

    logic [VLEN_MAX-1:0] tail_bits;
    always_comb begin
        for (int i = 0; i < VLEN_MAX; i++)
            tail_bits[i] = mask[i] && (LW'(i) >= vl);
    end

    // R9
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (LW'(idx) < vl));

    // R9
    busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R6
    mask_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(busy) && is_cmp(cur_ctl.op)) |-> (tail_bits == '0));
endmodule

// File: rtl/vmask_exec_unit.sv
`timescale 1ns/1ps
module vmask_exec_unit
    import vexu_pkg::*;
#(
    parameter int N_REGS   = 8,
    parameter int VLEN_MAX = 16,
    parameter int ELEM_W   = 16,
    localparam int RW      = $clog2(N_REGS),
    localparam int IDXW    = $clog2(VLEN_MAX),
    localparam int LW      = $clog2(VLEN_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [3:0]          in_op,
    input  logic                in_use_scalar,
    input  logic                in_mask_en,
    input  logic [RW-1:0]       in_dst,
    input  logic [RW-1:0]       in_src_a,
    input  logic [RW-1:0]       in_src_b,
    input  logic [ELEM_W-1:0]   in_scalar,
    input  logic                fill_en,
    input  logic [RW-1:0]       fill_reg,
    input  logic [IDXW-1:0]     fill_idx,
    input  logic [ELEM_W-1:0]   fill_data,
    input  logic [RW-1:0]       rd_reg,
    input  logic [IDXW-1:0]     rd_idx,
    output logic [ELEM_W-1:0]   rd_data,
    output logic [LW-1:0]       vlen,
    output logic [VLEN_MAX-1:0] mask_bits,
    output logic                busy,
    output logic                done
);
    vctl_t             in_ctl, cur_ctl;
    logic [IDXW-1:0]   idx;
    logic [RW-1:0]     cur_dst, cur_a, cur_b;
    logic [ELEM_W-1:0] cur_scalar, a_elem, b_elem, op_a, alu_res;
    logic              rel_bit, exec_we;
    logic              rf_we;
    logic [RW-1:0]     rf_wreg;
    logic [IDXW-1:0]   rf_widx;
    logic [ELEM_W-1:0] rf_wdata;

    assign in_ctl   = '{op: vop_e'(in_op), use_scalar: in_use_scalar, mask_en: in_mask_en};
    assign in_ready = !busy;

    vexu_seq #(.N_REGS(N_REGS), .VLEN_MAX(VLEN_MAX), .ELEM_W(ELEM_W)) seq_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctl(in_ctl),
        .in_dst(in_dst), .in_a(in_src_a), .in_b(in_src_b), .in_scalar(in_scalar),
        .rel_bit(rel_bit), .busy(busy), .done(done), .idx(idx), .vl(vlen),
        .mask(mask_bits), .cur_ctl(cur_ctl), .cur_dst(cur_dst), .cur_a(cur_a),
        .cur_b(cur_b), .cur_scalar(cur_scalar)
    );

    assign op_a = cur_ctl.use_scalar ? cur_scalar : a_elem;

    vexu_alu #(.ELEM_W(ELEM_W)) alu_i (
        .op(cur_ctl.op), .a(op_a), .b(b_elem), .res(alu_res), .rel(rel_bit)
    );

    assign exec_we  = busy && is_arith(cur_ctl.op) && (!cur_ctl.mask_en || mask_bits[idx]);
    assign rf_we    = busy ? exec_we : fill_en;
    assign rf_wreg  = busy ? cur_dst : fill_reg;
    assign rf_widx  = busy ? idx     : fill_idx;
    assign rf_wdata = busy ? alu_res : fill_data;

    vexu_regfile #(.N_REGS(N_REGS), .VLEN_MAX(VLEN_MAX), .ELEM_W(ELEM_W)) rf_i (
        .clk(clk), .rst(rst), .we(rf_we), .wreg(rf_wreg), .widx(rf_widx),
        .wdata(rf_wdata), .ra_reg(cur_a), .rb_reg(cur_b), .rab_idx(idx),
        .ra_data(a_elem), .rb_data(b_elem), .rc_reg(rd_reg), .rc_idx(rd_idx),
        .rc_data(rd_data)
    );

    // R8
    wr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        exec_we |-> (LW'(rf_widx) < vlen));

    // R2
    setl_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && vop_e'(in_op) == VOP_SETL) |=> (done && !busy));
endmodule

// File: tb/vmask_exec_unit_tb_top.sv
`timescale 1ns/1ps
module vmask_exec_unit_tb_top;

    typedef struct packed {
        logic [3:0]  op;
        logic        us;
        logic        me;
        logic [2:0]  d;
        logic [2:0]  a;
        logic [2:0]  b;
        logic [15:0] sc;
        logic [4:0]  vl;
    } tb_vec_t;

    localparam int NV = 14;
    localparam tb_vec_t TBL [NV] = '{
        '{4'd0, 1'b0, 1'b0, 3'd3, 3'd1, 3'd2, 16'd0,     5'd16},
        '{4'd1, 1'b0, 1'b0, 3'd4, 3'd1, 3'd2, 16'd0,     5'd16},
        '{4'd2, 1'b0, 1'b0, 3'd5, 3'd1, 3'd2, 16'd0,     5'd16},
        '{4'd3, 1'b0, 1'b0, 3'd6, 3'd1, 3'd2, 16'd0,     5'd10},
        '{4'd0, 1'b1, 1'b0, 3'd3, 3'd0, 3'd2, 16'd7,     5'd16},
        '{4'd1, 1'b1, 1'b0, 3'd4, 3'd0, 3'd1, 16'd100,   5'd5},
        '{4'd4, 1'b0, 1'b0, 3'd5, 3'd1, 3'd1, 16'd0,     5'd16},
        '{4'd5, 1'b0, 1'b0, 3'd0, 3'd1, 3'd2, 16'd0,     5'd16},
        '{4'd0, 1'b0, 1'b1, 3'd6, 3'd1, 3'd2, 16'd0,     5'd16},
        '{4'd7, 1'b0, 1'b0, 3'd0, 3'd1, 3'd2, 16'd0,     5'd7},
        '{4'd1, 1'b0, 1'b1, 3'd3, 3'd2, 3'd1, 16'd0,     5'd12},
        '{4'd6, 1'b1, 1'b0, 3'd0, 3'd0, 3'd2, 16'd400,   5'd16},
        '{4'd3, 1'b1, 1'b1, 3'd7, 3'd0, 3'd1, 16'h00F0,  5'd16},
        '{4'd0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd1, 16'd32000, 5'd16}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_ready;
    logic [3:0]  in_op = '0;
    logic        in_use_scalar = 1'b0, in_mask_en = 1'b0;
    logic [2:0]  in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic [15:0] in_scalar = '0;
    logic        fill_en = 1'b0;
    logic [2:0]  fill_reg = '0;
    logic [3:0]  fill_idx = '0;
    logic [15:0] fill_data = '0;
    logic [2:0]  rd_reg = '0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic [4:0]  vlen;
    logic [15:0] mask_bits;
    logic        busy, done;

    always #10ns clk = ~clk;

    vmask_exec_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_use_scalar(in_use_scalar), .in_mask_en(in_mask_en),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_scalar(in_scalar), .fill_en(fill_en), .fill_reg(fill_reg),
        .fill_idx(fill_idx), .fill_data(fill_data), .rd_reg(rd_reg),
        .rd_idx(rd_idx), .rd_data(rd_data), .vlen(vlen), .mask_bits(mask_bits),
        .busy(busy), .done(done)
    );

    int n_checks = 0;
    int n_errors = 0;
    logic signed [15:0] m_reg [8][16];
    logic [15:0] m_mask = '0;
    int m_vl = 16;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(2_000_000ns);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        summary();
    end

    function automatic string req_of(tb_vec_t v);
        if (v.op == 4'd8) return "R2";
        if (v.op >= 4'd5) return "R6";
        if (v.me) return "R7";
        if (v.op == 4'd4) return "R5";
        if (v.us) return "R4";
        return "R3";
    endfunction

    task automatic model_apply(tb_vec_t v);
        logic signed [15:0] av, bv, rv;
        bit rl;
        if (v.op == 4'd8) begin
            m_vl = (v.sc > 16'd16) ? 16 : int'(v.sc);
            return;
        end
        if (m_vl == 0 || v.op > 4'd7) return;
        if (v.op >= 4'd5) m_mask = '0;
        for (int i = 0; i < m_vl; i++) begin
            av = v.us ? signed'(v.sc) : m_reg[v.a][i];
            bv = m_reg[v.b][i];
            case (v.op)
                4'd0: rv = av + bv;
                4'd1: rv = av - bv;
                4'd2: rv = av & bv;
                4'd3: rv = av | bv;
                4'd4: rv = -bv;
                default: rv = '0;
            endcase
            rl = (v.op == 4'd5) ? (av > bv) : (v.op == 4'd6) ? (av == bv) : (av < bv);
            if (v.op >= 4'd5) m_mask[i] = rl;
            else if (!v.me || m_mask[i]) m_reg[v.d][i] = rv;
        end
    endtask

    task automatic check_reg(int r, string req);
        int bad = -1;
        int act = 0;
        int exp = 0;
        for (int i = 0; i < 16; i++) begin
            rd_reg = 3'(r);
            rd_idx = 4'(i);
            #1ns;
            if (rd_data !== m_reg[r][i] && bad < 0) begin
                bad = i;
                act = int'(signed'(rd_data));
                exp = int'(m_reg[r][i]);
            end
        end
        chk(bad < 0, (bad >= m_vl) ? "R8" : req, $sformatf("reg %0d elem %0d", r, bad), act, exp);
    endtask

    task automatic drive(tb_vec_t v);
        in_op = v.op; in_use_scalar = v.us; in_mask_en = v.me;
        in_dst = v.d; in_src_a = v.a; in_src_b = v.b; in_scalar = v.sc;
    endtask

    task automatic run(tb_vec_t v);
        int cyc = 0;
        int exp_cyc;
        bit bad_busy = 0;
        string req = req_of(v);
        exp_cyc = (v.op >= 4'd8 || m_vl == 0) ? 0 : m_vl;
        @(negedge clk);
        drive(v);
        in_valid = 1'b1;
        chk(in_ready == 1'b1, "R9", "in_ready when idle", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        while (!done && cyc < 64) begin
            if (!busy) bad_busy = 1;
            cyc++;
            @(negedge clk);
        end
        chk(cyc == exp_cyc && !bad_busy && !busy, "R9", "cycles to done", cyc, exp_cyc);
        model_apply(v);
        if (v.op == 4'd8)
            chk(int'(vlen) == m_vl, "R2", "length", int'(vlen), m_vl);
        else if (v.op >= 4'd5) begin
            chk(mask_bits == m_mask, "R6", "mask", int'(mask_bits), int'(m_mask));
            check_reg(v.d, "R6");
        end else
            check_reg(v.d, req);
    endtask

    task automatic set_len(int l);
        tb_vec_t s = '{4'd8, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 16'(l), 5'd0};
        run(s);
    endtask

    task automatic fill(int r, int i, logic [15:0] val);
        @(negedge clk);
        fill_en = 1'b1; fill_reg = 3'(r); fill_idx = 4'(i); fill_data = val;
        @(negedge clk);
        fill_en = 1'b0;
        m_reg[r][i] = val;
    endtask

    initial begin
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 16; i++)
                m_reg[r][i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && in_ready, "R1", "busy/done/ready", int'({busy, done, in_ready}), 1);
        chk(vlen == 5'd16, "R1", "length after reset", int'(vlen), 16);
        chk(mask_bits == '0, "R1", "mask after reset", int'(mask_bits), 0);
        check_reg(3, "R1");

        // R10 fill while idle, R11 read port
        for (int i = 0; i < 16; i++) begin
            fill(1, i, 16'(300 * i - 2000));
            fill(2, i, 16'(1000 - 150 * i));
        end
        check_reg(1, "R10");
        check_reg(2, "R11");

        // stimulus table: R3..R8
        for (int k = 0; k < NV; k++) begin
            if (int'(TBL[k].vl) != m_vl) set_len(int'(TBL[k].vl));
            run(TBL[k]);
        end

        // R10: instruction offer and fill during a running operation are ignored
        begin
            tb_vec_t main_op = '{4'd0, 1'b0, 1'b0, 3'd3, 3'd1, 3'd2, 16'd0, 5'd16};
            tb_vec_t intruder = '{4'd1, 1'b0, 1'b0, 3'd7, 3'd1, 3'd1, 16'd0, 5'd16};
            int cyc = 0;
            @(negedge clk);
            drive(main_op);
            in_valid = 1'b1;
            @(negedge clk);
            drive(intruder);
            fill_en = 1'b1; fill_reg = 3'd7; fill_idx = 4'd0; fill_data = 16'd1234;
            chk(in_ready == 1'b0, "R10", "in_ready while busy", int'(in_ready), 0);
            repeat (3) @(negedge clk);
            in_valid = 1'b0;
            fill_en = 1'b0;
            while (!done && cyc < 64) begin
                cyc++;
                @(negedge clk);
            end
            model_apply(main_op);
            check_reg(7, "R10");
            check_reg(3, "R3");
        end

        // R9: zero length does nothing, R2: clamp
        set_len(0);
        run('{4'd1, 1'b0, 1'b0, 3'd7, 3'd1, 3'd1, 16'd0, 5'd0});
        check_reg(7, "R9");
        set_len(40);
        chk(vlen == 5'd16, "R2", "clamped length", int'(vlen), 16);

        summary();
    end
endmodule